// File: doc/BRIEF.md
# Auto-Reload Up/Down Timer

This block is a 16-bit timer/counter with a software-loaded reload register and one asynchronous control input, `extIn`. It advances only on cycles where `tickEn` is high. `tickEn` is driven either by a timer tick or by a counter pulse that has already been synchronized. A control bit called direction mode selects between two behaviours.

With direction mode cleared, the counter only counts up. It wraps from all ones to the reload value, and it can also reload on a falling edge of `extIn`. With direction mode set, the level of `extIn` sets the count direction. A downward wrap happens when the count matches the reload value, and the counter then restarts from all ones. An external flag toggles on every wrap, so it acts as a seventeenth count bit.

Software reaches the count, reload value, control bits and flags through a small write/read port. `irq` combines the flags with an interrupt enable.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset, the count, reload, control and flag registers read 0. Direction mode is off, so the counter counts up on every `tickEn` whatever level `extIn` has.
- R2: With direction mode off, a step taken at count 0xFFFF sets the overflow flag (flags bit 0) and loads the count from the reload register.
- R3: With direction mode off and the external-enable bit set (control bit 1), a falling edge of `extIn` reloads the count and sets the external flag (flags bit 1), whether `tickEn` is high or not. `extIn` passes through two synchronizer stages, so the reload lands on the third rising clock edge after the input falls, and each edge causes exactly one reload.
- R4: With direction mode on (control bit 0) and the synchronized `extIn` high, the counter counts up. A step at 0xFFFF sets the overflow flag and reloads from the reload register.
- R5: With direction mode on and the synchronized `extIn` low, the counter counts down. A step taken while the count equals the reload value sets the overflow flag and loads 0xFFFF.
- R6: With direction mode on, the external flag toggles on every upward and downward wrap, and the external flag never asserts `irq`.
- R7: `irq` is high when the interrupt-enable bit (control bit 2) is set and either the overflow flag is set or, with direction mode off, the external flag is set.
- R8: Writing the flags register clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged. A hardware set or toggle in the same cycle takes priority over the software clear.
- R9: With `tickEn` low and no register write and no edge reload, the count holds.
- R10: A write to the count register takes priority over a count step in the same cycle.
- R11: The register addresses are count at 0, reload at 1, control at 2 and flags at 3. Unused control and flag bits read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| tickEn | input | 1 | Count enable for this cycle |
| extIn | input | 1 | Asynchronous external control input |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Combinational read data for `regAddr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a direction change just as `extIn` crosses the synchronizer. For one or two steps, the counter must still follow the old level, and only after that the new one. The stimulus therefore runs a down-count into an underflow and then raises `extIn` while `tickEn` stays high. The expected counts hold the down direction for exactly two more steps before the count turns upward and wraps to the reload value. Collisions are also steered into the same cycle: a flag clear together with a wrap, and a count write together with a step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] SEL_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] SEL_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] SEL_FLAGS  = 2'd3;
  localparam int CTL_DIR = 0;
  localparam int CTL_EXT = 1;
  localparam int CTL_IRQ = 2;
  localparam int FLG_OVF = 0;
  localparam int FLG_EXT = 1;

  typedef struct packed {
    logic inc;
    logic dec;
    logic loadReload;
    logic loadOnes;
    logic setOvf;
    logic setExt;
    logic toggleExt;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             extIn,
  input  logic             dirMode,
  input  logic             extEn,
  input  logic [WIDTH-1:0] count,
  input  logic [WIDTH-1:0] reload,
  output tmrStrobe_t       strobe
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [SYNC_STAGES-1:0] syncQ;
  logic extPrev;
  logic extLevel;
  logic extFall;
  logic upStep, downStep, wrapUp, wrapDown, edgeReload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extIn};
      extPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign extLevel = syncQ[SYNC_STAGES-1];
  assign extFall  = extPrev & ~extLevel;

  always_comb begin
    upStep     = tickEn & (~dirMode | extLevel);
    downStep   = tickEn & dirMode & ~extLevel;
    wrapUp     = upStep & (count == ALL_ONES);
    wrapDown   = downStep & (count == reload);
    edgeReload = ~dirMode & extEn & extFall;
    strobe.loadReload = wrapUp | edgeReload;
    strobe.loadOnes   = wrapDown;
    strobe.inc        = upStep & ~wrapUp;
    strobe.dec        = downStep & ~wrapDown;
    strobe.setOvf     = wrapUp | wrapDown;
    strobe.setExt     = edgeReload;
    strobe.toggleExt  = dirMode & (wrapUp | wrapDown);
  end

  assert_one_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    edgeReload |=> !edgeReload);
  assert_no_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |-> !(strobe.inc || strobe.dec || strobe.loadOnes || strobe.setOvf));
  assert_one_way_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(upStep && downStep));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  output logic [WIDTH-1:0]  count,
  output logic [WIDTH-1:0]  reload,
  output logic              dirMode,
  output logic              extEn,
  output logic              irqEn,
  output logic              ovfFlag,
  output logic              extFlag
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic wrCount, wrReload, wrCtrl, wrFlags;
  logic [WIDTH-1:0] countNext;
  logic ovfNext, extNext;

  assign wrCount  = regWe && (regAddr == SEL_COUNT);
  assign wrReload = regWe && (regAddr == SEL_RELOAD);
  assign wrCtrl   = regWe && (regAddr == SEL_CTRL);
  assign wrFlags  = regWe && (regAddr == SEL_FLAGS);

  always_comb begin
    if (wrCount)                countNext = regWdata;
    else if (strobe.loadReload) countNext = reload;
    else if (strobe.loadOnes)   countNext = ALL_ONES;
    else if (strobe.inc)        countNext = count + 1'b1;
    else if (strobe.dec)        countNext = count - 1'b1;
    else                        countNext = count;

    if (strobe.setOvf)     ovfNext = 1'b1;
    else if (wrFlags)      ovfNext = ovfFlag & regWdata[FLG_OVF];
    else                   ovfNext = ovfFlag;

    if (strobe.toggleExt)  extNext = ~extFlag;
    else if (strobe.setExt) extNext = 1'b1;
    else if (wrFlags)      extNext = extFlag & regWdata[FLG_EXT];
    else                   extNext = extFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      reload  <= '0;
      dirMode <= 1'b0;
      extEn   <= 1'b0;
      irqEn   <= 1'b0;
      ovfFlag <= 1'b0;
      extFlag <= 1'b0;
    end else begin
      count   <= countNext;
      ovfFlag <= ovfNext;
      extFlag <= extNext;
      if (wrReload) reload <= regWdata;
      if (wrCtrl) begin
        dirMode <= regWdata[CTL_DIR];
        extEn   <= regWdata[CTL_EXT];
        irqEn   <= regWdata[CTL_IRQ];
      end
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      SEL_COUNT:  regRdata = count;
      SEL_RELOAD: regRdata = reload;
      SEL_CTRL: begin
        regRdata[CTL_DIR] = dirMode;
        regRdata[CTL_EXT] = extEn;
        regRdata[CTL_IRQ] = irqEn;
      end
      default: begin
        regRdata[FLG_OVF] = ovfFlag;
        regRdata[FLG_EXT] = extFlag;
      end
    endcase
  end

  assert_wrap_up_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadReload && !wrCount && !wrReload) |=> count == $past(reload));
  assert_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadOnes && !wrCount) |=> count == ALL_ONES);
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvf |=> ovfFlag);
  assert_ext_toggle_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.toggleExt |=> extFlag != $past(extFlag));
  assert_count_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrCount |=> count == $past(regWdata));
endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              extIn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  output logic              irq
);
  tmrStrobe_t strobe;
  logic [WIDTH-1:0] count, reload;
  logic dirMode, extEn, irqEn, ovfFlag, extFlag;

  tmr_ctrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extIn(extIn),
    .dirMode(dirMode), .extEn(extEn), .count(count), .reload(reload),
    .strobe(strobe)
  );

  tmr_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .count(count), .reload(reload), .dirMode(dirMode), .extEn(extEn),
    .irqEn(irqEn), .ovfFlag(ovfFlag), .extFlag(extFlag)
  );

  assign irq = irqEn & (ovfFlag | (~dirMode & extFlag));

  assert_irq_dir_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dirMode && !ovfFlag) |-> !irq);
endmodule

// File: tb/test_updown_reload_timer.sv
module test_updown_reload_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic extIn = 1'b1;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic irq;

  int applied = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  updown_reload_timer i_updown_reload_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extIn(extIn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  // {we, addr, wdata, tick, ex, chkAddr, expData, expIrq, reqNum}
  localparam int NV = 33;
  localparam logic [43:0] VECS [NV] = '{
    {1'b1, 2'd1, 16'hFFFD, 1'b0, 1'b1, 2'd1, 16'hFFFD, 1'b0, 4'd11}, // R11 reload reg
    {1'b1, 2'd0, 16'hFFFE, 1'b0, 1'b1, 2'd0, 16'hFFFE, 1'b0, 4'd11},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 2'd0, 16'hFFFF, 1'b0, 4'd2},  // R2
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 2'd0, 16'hFFFD, 1'b0, 4'd2},  // R2 wrap
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd3, 16'h0001, 1'b0, 4'd2},
    {1'b1, 2'd3, 16'h0000, 1'b0, 1'b1, 2'd3, 16'h0000, 1'b0, 4'd8},  // R8
    {1'b1, 2'd2, 16'h0006, 1'b0, 1'b1, 2'd2, 16'h0006, 1'b0, 4'd11},
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 16'hFFFD, 1'b0, 4'd9},  // R9 hold
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd0, 16'hFFFE, 1'b0, 4'd3},
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 16'hFFFD, 1'b1, 4'd3},  // R3 edge reload
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd3, 16'h0002, 1'b1, 4'd7},  // R7
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd0, 16'hFFFD, 1'b1, 4'd3},
    {1'b1, 2'd3, 16'h0000, 1'b0, 1'b0, 2'd3, 16'h0000, 1'b0, 4'd8},
    {1'b1, 2'd2, 16'hFFF5, 1'b0, 1'b0, 2'd2, 16'h0005, 1'b0, 4'd11}, // R11 reserved
    {1'b1, 2'd1, 16'h0010, 1'b0, 1'b0, 2'd1, 16'h0010, 1'b0, 4'd11},
    {1'b1, 2'd0, 16'h0012, 1'b0, 1'b0, 2'd0, 16'h0012, 1'b0, 4'd10},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd0, 16'h0011, 1'b0, 4'd5},  // R5
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd0, 16'h0010, 1'b0, 4'd5},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 2'd0, 16'hFFFF, 1'b1, 4'd5},  // R5 underflow
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 2'd3, 16'h0003, 1'b1, 4'd6},  // R6
    {1'b1, 2'd3, 16'h0001, 1'b0, 1'b0, 2'd3, 16'h0001, 1'b1, 4'd8},
    {1'b1, 2'd3, 16'h0000, 1'b0, 1'b0, 2'd3, 16'h0000, 1'b0, 4'd8},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 2'd0, 16'hFFFE, 1'b0, 4'd5},  // sync lag
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 2'd0, 16'hFFFD, 1'b0, 4'd5},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 2'd0, 16'hFFFE, 1'b0, 4'd4},  // R4
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 2'd0, 16'hFFFF, 1'b0, 4'd4},
    {1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 2'd0, 16'h0010, 1'b1, 4'd4},
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd3, 16'h0003, 1'b1, 4'd6},
    {1'b1, 2'd3, 16'h0002, 1'b0, 1'b1, 2'd3, 16'h0002, 1'b0, 4'd6},  // R6 no irq
    {1'b1, 2'd0, 16'hFFFF, 1'b0, 1'b1, 2'd0, 16'hFFFF, 1'b0, 4'd10},
    {1'b1, 2'd3, 16'h0000, 1'b1, 1'b1, 2'd3, 16'h0001, 1'b1, 4'd8},  // R8 hw wins
    {1'b1, 2'd0, 16'h1234, 1'b1, 1'b1, 2'd0, 16'h1234, 1'b1, 4'd10}, // R10
    {1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 2'd0, 16'h1234, 1'b1, 4'd9}
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    regWe = 1'b0;
    tickEn = 1'b0;
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state of every register and irq
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], d);
      check(1, d, 16'h0000);
    end
    check(1, {15'd0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VECS[i];
      @(negedge clk);
      regWe = v[43]; regAddr = v[42:41]; regWdata = v[40:25];
      tickEn = v[24]; extIn = v[23];
      @(posedge clk);
      #1;
      readReg(v[22:21], d);
      check(int'(v[3:0]), d, v[20:5]);
      check(int'(v[3:0]), {15'd0, irq}, {15'd0, v[4]});
    end

    // R1: after reset, counts up even with extIn held low
    @(negedge clk);
    extIn = 1'b0; rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    readReg(2'd2, d);
    check(1, d, 16'h0000);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (3) @(negedge clk);
    readReg(2'd0, d);
    check(1, d, 16'h0003);

    // R3: falling edge ignored with external enable clear
    @(negedge clk);
    extIn = 1'b1;
    repeat (4) @(negedge clk);
    extIn = 1'b0;
    repeat (5) @(negedge clk);
    readReg(2'd0, d);
    check(3, d, 16'h0003);
    readReg(2'd3, d);
    check(3, d, 16'h0000);
    finishRun();
  end
endmodule